// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular store for the results of instructions that have finished executing but have not yet been made architecturally visible. At issue, a caller requests a slot through an allocate stream. The slot index handed back is the rename tag. Later consumers wait for that tag instead of a register name. When an execution unit finishes, its result is broadcast with that tag and is captured into the matching slot. Until the slot retires, operand lookup ports can fetch the result by register name. The block keeps a register-status table that records which slot will produce the newest value of each architectural register.

Retirement happens strictly in allocation order. The oldest slot is offered on a commit stream once its result is present. When the consumer accepts it, the register file is written, or for a store the memory write is performed. A branch found to be mispredicted at the moment it retires discards every younger slot. A separate flush input does the same for an exception. In both cases all pointers, valid bits and register-status mappings are reset in one cycle.

The allocate and commit interfaces are valid/ready streams. An allocation transfers only on a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` falls when the buffer is full, while `flush_in` is high, or while a completed mispredicted branch waits at the head. A commit transfers only on a cycle where `cm_valid` and `cm_ready` are both high. While `cm_ready` is low, the offered entry stays in place and unchanged. The result write port has no ready signal and is always accepted.

Top module: `reorder_retire`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready`=1, `cm_valid`=0, and every lookup port reports `look_busy`=0.
- R2: Each accepted allocation returns `alloc_tag` equal to the tail slot. Tags increase by one per allocation, modulo DEPTH, and restart at 0 after reset or after any flush.
- R3: After DEPTH allocations with no commit, `alloc_ready` is 0. An `alloc_valid` held while not ready changes no state: the next granted tag after the commits is unchanged.
- R4: A result write with `wb_valid`=1 stores `wb_value` and `wb_mispredict` into slot `wb_tag` and marks it complete. A result write to a free slot is discarded.
- R5: For a register whose newest producer has not retired, a lookup port gives `look_busy`=1 and `look_tag`=producer slot. It gives `look_ready`=1 and `look_value`=result once that slot is complete, and `look_ready`=0 before. When several slots target one register, the latest allocated one is reported.
- R6: `cm_valid` is 1 only when the oldest slot is complete. Slots completed in any order retire in allocation order, with the tag, kind, destination and value captured for them.
- R7: While `cm_valid`=1 and `cm_ready`=0, the commit payload stays valid and unchanged.
- R8: When a register-writing slot retires, the register's mapping is released only if it still names that slot. A newer pending producer stays visible.
- R9: Kind encoding is 0 = register write, 1 = store, 2 = branch. Only kind 0 installs a register mapping. A store or branch leaves lookups of its destination field not busy.
- R10: With `flush_in`=1, `alloc_ready` and `cm_valid` are 0. In the next cycle the buffer is empty and every mapping is clear.
- R11: A complete branch with its mispredict flag set, at the head, holds `alloc_ready` at 0 and is offered with `cm_mispredict`=1. Its retirement empties the buffer and clears all mappings in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_in | input | 1 | Discard all slots (exception) |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Slot available for allocation |
| alloc_kind | input | 2 | Kind of issuing instruction (0 reg, 1 store, 2 branch) |
| alloc_dest | input | $clog2(ARCH_REGS) | Destination register or destination field |
| alloc_tag | output | $clog2(DEPTH) | Slot index granted, the rename tag |
| wb_valid | input | 1 | Result broadcast present |
| wb_tag | input | $clog2(DEPTH) | Slot the result belongs to |
| wb_value | input | DATA_W | Result value |
| wb_mispredict | input | 1 | Branch outcome disagrees with prediction |
| look_reg | input | NUM_LOOKUP*$clog2(ARCH_REGS) | Register queried per lookup port |
| look_busy | output | NUM_LOOKUP | Register has a pending producer |
| look_tag | output | NUM_LOOKUP*$clog2(DEPTH) | Producer slot per port |
| look_ready | output | NUM_LOOKUP | Producer result is present |
| look_value | output | NUM_LOOKUP*DATA_W | Producer result per port |
| cm_valid | output | 1 | Oldest slot ready to retire |
| cm_ready | input | 1 | Consumer accepts retirement |
| cm_tag | output | $clog2(DEPTH) | Slot retiring |
| cm_kind | output | 2 | Kind of retiring slot |
| cm_dest | output | $clog2(ARCH_REGS) | Destination of retiring slot |
| cm_value | output | DATA_W | Result of retiring slot |
| cm_mispredict | output | 1 | Retiring branch was mispredicted |

## Verification
On every cycle, assertions check the following. The occupancy counter agrees with the number of live slots, and no allocation is taken when full. Both kinds of flush leave the pointers and the whole register-status table cleared one cycle later. A back-pressured commit holds its payload. A release never drops a mapping that names a newer slot. A result aimed at a free slot never marks it complete. Only the bench scenarios can show the data-level behaviour. This covers retirement in allocation order for every completion order of a full buffer, the values and tags seen on the lookup ports, tag wrap-around and restart after flushes, and the kind-dependent handling of mappings.

// File: rtl/retire_pkg.sv
package retire_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) tail_q <= wrap_inc(tail_q);
      if (pop)  head_q <= wrap_inc(head_q);
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign count = count_q;
  assign full  = (count_q == CNT_W'(DEPTH));

  // R3: never accept an allocation into a full buffer
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count_q < CNT_W'(DEPTH)));

  // R10 / R11: any flush leaves pointers at zero next cycle
  a_r10_flush_resets_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0 && head_q == '0 && tail_q == '0));
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_en,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [1:0]        alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_value,
  input  logic              wb_misp,
  input  logic              free_en,
  input  logic [IDX_W-1:0]  free_idx,
  output logic [DEPTH-1:0]  valid_vec,
  output logic [DEPTH-1:0]  done_vec,
  output logic [DEPTH-1:0]  misp_vec,
  output logic [1:0]        kind_arr  [DEPTH],
  output logic [REG_W-1:0]  dest_arr  [DEPTH],
  output logic [DATA_W-1:0] value_arr [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit_alloc, hit_wb, hit_free;
    assign hit_alloc = alloc_en && (alloc_idx == IDX_W'(i));
    assign hit_wb    = wb_en && (wb_idx == IDX_W'(i)) && valid_vec[i] && !hit_alloc;
    assign hit_free  = free_en && (free_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[i] <= 1'b0;
        done_vec[i]  <= 1'b0;
        misp_vec[i]  <= 1'b0;
        kind_arr[i]  <= '0;
        dest_arr[i]  <= '0;
        value_arr[i] <= '0;
      end else if (flush) begin
        valid_vec[i] <= 1'b0;
        done_vec[i]  <= 1'b0;
      end else begin
        if (hit_alloc) begin
          valid_vec[i] <= 1'b1;
          done_vec[i]  <= 1'b0;
          misp_vec[i]  <= 1'b0;
          kind_arr[i]  <= alloc_kind;
          dest_arr[i]  <= alloc_dest;
        end else if (hit_free) begin
          valid_vec[i] <= 1'b0;
          done_vec[i]  <= 1'b0;
        end
        if (hit_wb) begin
          done_vec[i]  <= 1'b1;
          value_arr[i] <= wb_value;
          misp_vec[i]  <= wb_misp;
        end
      end
    end
  end

  // R4: a result aimed at a free slot never marks it complete
  a_r4_drop_stale_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !valid_vec[wb_idx] && !flush && !(alloc_en && alloc_idx == wb_idx))
      |=> !done_vec[$past(wb_idx)]);
endmodule

// File: rtl/rob_rename_map.sv
module rob_rename_map #(
  parameter int ARCH_REGS = 16,
  parameter int IDX_W     = 3,
  localparam int REG_W    = $clog2(ARCH_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 set_en,
  input  logic [REG_W-1:0]     set_reg,
  input  logic [IDX_W-1:0]     set_tag,
  input  logic                 clr_en,
  input  logic [REG_W-1:0]     clr_reg,
  input  logic [IDX_W-1:0]     clr_tag,
  output logic [ARCH_REGS-1:0] busy_vec,
  output logic [IDX_W-1:0]     tag_arr [ARCH_REGS]
);
  for (genvar r = 0; r < ARCH_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        busy_vec[r] <= 1'b0;
        tag_arr[r]  <= '0;
      end else if (set_en && set_reg == REG_W'(r)) begin
        busy_vec[r] <= 1'b1;
        tag_arr[r]  <= set_tag;
      end else if (clr_en && clr_reg == REG_W'(r) && busy_vec[r] && tag_arr[r] == clr_tag) begin
        busy_vec[r] <= 1'b0;
      end
    end
  end

  // R8: a release naming an older slot keeps the newer mapping
  a_r8_keep_newer_map: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en && !flush && busy_vec[clr_reg] && tag_arr[clr_reg] != clr_tag)
      |=> busy_vec[$past(clr_reg)]);

  // R10: every flush empties the mapping table
  a_r10_map_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_vec == '0));
endmodule

// File: rtl/rob_lookup.sv
module rob_lookup #(
  parameter int ARCH_REGS = 16,
  parameter int DEPTH     = 8,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int REG_W    = $clog2(ARCH_REGS)
) (
  input  logic [REG_W-1:0]     q_reg,
  input  logic [ARCH_REGS-1:0] map_busy,
  input  logic [IDX_W-1:0]     map_tag [ARCH_REGS],
  input  logic [DEPTH-1:0]     done_vec,
  input  logic [DATA_W-1:0]    value_arr [DEPTH],
  output logic                 busy,
  output logic [IDX_W-1:0]     tag,
  output logic                 ready,
  output logic [DATA_W-1:0]    value
);
  always_comb begin
    busy  = map_busy[q_reg];
    tag   = map_tag[q_reg];
    ready = busy && done_vec[tag];
    value = ready ? value_arr[tag] : '0;
  end
endmodule

// File: rtl/reorder_retire.sv
module reorder_retire
  import retire_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int DATA_W     = 32,
  parameter int ARCH_REGS  = 16,
  parameter int NUM_LOOKUP = 2,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int REG_W     = $clog2(ARCH_REGS),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_in,
  input  logic                         alloc_valid,
  output logic                         alloc_ready,
  input  logic [1:0]                   alloc_kind,
  input  logic [REG_W-1:0]             alloc_dest,
  output logic [IDX_W-1:0]             alloc_tag,
  input  logic                         wb_valid,
  input  logic [IDX_W-1:0]             wb_tag,
  input  logic [DATA_W-1:0]            wb_value,
  input  logic                         wb_mispredict,
  input  logic [NUM_LOOKUP*REG_W-1:0]  look_reg,
  output logic [NUM_LOOKUP-1:0]        look_busy,
  output logic [NUM_LOOKUP*IDX_W-1:0]  look_tag,
  output logic [NUM_LOOKUP-1:0]        look_ready,
  output logic [NUM_LOOKUP*DATA_W-1:0] look_value,
  output logic                         cm_valid,
  input  logic                         cm_ready,
  output logic [IDX_W-1:0]             cm_tag,
  output logic [1:0]                   cm_kind,
  output logic [REG_W-1:0]             cm_dest,
  output logic [DATA_W-1:0]            cm_value,
  output logic                         cm_mispredict
);
  logic [IDX_W-1:0]     head, tail;
  logic [CNT_W-1:0]     count;
  logic                 full;
  logic [DEPTH-1:0]     valid_vec, done_vec, misp_vec;
  logic [1:0]           kind_arr  [DEPTH];
  logic [REG_W-1:0]     dest_arr  [DEPTH];
  logic [DATA_W-1:0]    value_arr [DEPTH];
  logic [ARCH_REGS-1:0] map_busy;
  logic [IDX_W-1:0]     map_tag [ARCH_REGS];

  logic head_live, head_branch, head_misp_done;
  logic alloc_fire, cm_fire, flush_all;

  always_comb begin
    head_live      = valid_vec[head] && done_vec[head];
    head_branch    = (kind_e'(kind_arr[head]) == KIND_BRANCH);
    head_misp_done = head_live && head_branch && misp_vec[head];
    alloc_ready    = !full && !flush_in && !head_misp_done;
    alloc_fire     = alloc_valid && alloc_ready;
    cm_valid       = !flush_in && head_live;
    cm_fire        = cm_valid && cm_ready;
    flush_all      = flush_in || (cm_fire && head_misp_done);
  end

  assign alloc_tag     = tail;
  assign cm_tag        = head;
  assign cm_kind       = kind_arr[head];
  assign cm_dest       = dest_arr[head];
  assign cm_value      = value_arr[head];
  assign cm_mispredict = head_branch && misp_vec[head];

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush_all),
    .push  (alloc_fire),
    .pop   (cm_fire),
    .head  (head),
    .tail  (tail),
    .count (count),
    .full  (full)
  );

  rob_entries #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u_entries (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_all),
    .alloc_en   (alloc_fire),
    .alloc_idx  (tail),
    .alloc_kind (alloc_kind),
    .alloc_dest (alloc_dest),
    .wb_en      (wb_valid),
    .wb_idx     (wb_tag),
    .wb_value   (wb_value),
    .wb_misp    (wb_mispredict),
    .free_en    (cm_fire),
    .free_idx   (head),
    .valid_vec  (valid_vec),
    .done_vec   (done_vec),
    .misp_vec   (misp_vec),
    .kind_arr   (kind_arr),
    .dest_arr   (dest_arr),
    .value_arr  (value_arr)
  );

  rob_rename_map #(.ARCH_REGS(ARCH_REGS), .IDX_W(IDX_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_all),
    .set_en   (alloc_fire && kind_e'(alloc_kind) == KIND_REG),
    .set_reg  (alloc_dest),
    .set_tag  (tail),
    .clr_en   (cm_fire && kind_e'(kind_arr[head]) == KIND_REG),
    .clr_reg  (dest_arr[head]),
    .clr_tag  (head),
    .busy_vec (map_busy),
    .tag_arr  (map_tag)
  );

  for (genvar p = 0; p < NUM_LOOKUP; p++) begin : g_look
    rob_lookup #(.ARCH_REGS(ARCH_REGS), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_look (
      .q_reg     (look_reg[p*REG_W +: REG_W]),
      .map_busy  (map_busy),
      .map_tag   (map_tag),
      .done_vec  (done_vec),
      .value_arr (value_arr),
      .busy      (look_busy[p]),
      .tag       (look_tag[p*IDX_W +: IDX_W]),
      .ready     (look_ready[p]),
      .value     (look_value[p*DATA_W +: DATA_W])
    );
  end

  // R6: occupancy counter matches the live slots
  a_r6_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_vec) == int'(count));

  // R7: back-pressured commit holds its payload
  a_r7_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready && !flush_in && !(wb_valid && wb_tag == head))
      |=> (cm_valid && $stable(cm_tag) && $stable(cm_value) && $stable(cm_dest)));

  // R11: retiring a mispredicted branch empties the buffer
  a_r11_misp_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_fire && cm_mispredict) |=> (count == '0 && map_busy == '0));
endmodule

// File: tb/reorder_retire_bench.sv
module reorder_retire_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D = 4;
  localparam int DW = 16;
  localparam int NR = 4;

  logic clk = 0, rst_n = 0, flush_in = 0;
  logic alloc_valid = 0, alloc_ready;
  logic [1:0] alloc_kind = 0;
  logic [1:0] alloc_dest = 0, alloc_tag;
  logic wb_valid = 0, wb_mispredict = 0;
  logic [1:0] wb_tag = 0;
  logic [DW-1:0] wb_value = 0;
  logic [3:0] look_reg = 0;
  logic [1:0] look_busy, look_ready;
  logic [3:0] look_tag;
  logic [31:0] look_value;
  logic cm_valid, cm_ready = 0, cm_mispredict;
  logic [1:0] cm_tag, cm_kind, cm_dest;
  logic [DW-1:0] cm_value;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reorder_retire #(.DEPTH(D), .DATA_W(DW), .ARCH_REGS(NR), .NUM_LOOKUP(2)) u_reorder_retire (
    .clk(clk), .rst_n(rst_n), .flush_in(flush_in),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_tag(alloc_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_mispredict(wb_mispredict),
    .look_reg(look_reg), .look_busy(look_busy), .look_tag(look_tag),
    .look_ready(look_ready), .look_value(look_value),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_tag(cm_tag), .cm_kind(cm_kind),
    .cm_dest(cm_dest), .cm_value(cm_value), .cm_mispredict(cm_mispredict)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic do_alloc(input int kind, input int dest, input int exp_tag);
    alloc_valid = 1; alloc_kind = 2'(kind); alloc_dest = 2'(dest);
    #1;
    chk("R2 alloc_ready", alloc_ready, 1);
    chk("R2 alloc_tag", alloc_tag, exp_tag);
    tick();
    alloc_valid = 0;
  endtask

  task automatic do_wb(input int tag, input int val, input bit misp);
    wb_valid = 1; wb_tag = 2'(tag); wb_value = DW'(val); wb_mispredict = misp;
    tick();
    wb_valid = 0; wb_mispredict = 0;
  endtask

  task automatic do_commit(input int tag, input int dest, input int val);
    cm_ready = 1;
    #1;
    chk("R6 cm_valid", cm_valid, 1);
    chk("R6 cm_tag", cm_tag, tag);
    chk("R6 cm_dest", cm_dest, dest);
    chk("R6 cm_value", cm_value, val);
    tick();
    cm_ready = 0;
  endtask

  task automatic look0(input int r);
    look_reg[1:0] = 2'(r);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    look_reg = 4'b0100;
    #1;
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 cm_valid", cm_valid, 0);
    chk("R1 look_busy", look_busy, 0);

    // R2 R3 R4 R5 R6 R8: every completion order of a full buffer
    for (int p = 0; p < 24; p++) begin
      int avail[4];
      int order[4];
      int rem, f, sel;
      bit wrote0;
      for (int i = 0; i < 4; i++) avail[i] = i;
      rem = p;
      for (int pos = 0; pos < 4; pos++) begin
        f = (pos == 0) ? 6 : (pos == 1) ? 2 : 1;
        sel = rem / f;
        rem = rem % f;
        order[pos] = avail[sel];
        for (int j = sel; j < 3; j++) avail[j] = avail[j+1];
      end
      for (int k = 0; k < 4; k++) do_alloc(0, k, k);
      // R3 full: refused request changes nothing
      alloc_valid = 1;
      #1;
      chk("R3 full alloc_ready", alloc_ready, 0);
      tick();
      alloc_valid = 0;
      wrote0 = 0;
      for (int pos = 0; pos < 4; pos++) begin
        do_wb(order[pos], p*16 + order[pos] + 1, 0);
        if (order[pos] == 0) wrote0 = 1;
        #1;
        chk("R6 cm_valid needs head done", cm_valid, int'(wrote0));
      end
      // R5 lookups on both ports
      for (int k = 0; k < 4; k++) begin
        look_reg = {2'((k+1)%4), 2'(k)};
        #1;
        chk("R5 busy", look_busy, 3);
        chk("R5 tag0", look_tag[1:0], k);
        chk("R5 tag1", look_tag[3:2], (k+1)%4);
        chk("R5 ready", look_ready, 3);
        chk("R5 value0", look_value[15:0], p*16 + k + 1);
        chk("R5 value1", look_value[31:16], p*16 + (k+1)%4 + 1);
      end
      for (int k = 0; k < 4; k++) do_commit(k, k, p*16 + k + 1);
      for (int k = 0; k < 4; k++) begin
        look0(k);
        chk("R8 released", look_busy[0], 0);
      end
    end

    // R7 back-pressure
    do_alloc(0, 1, 0);
    do_wb(0, 4321, 0);
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R7 held valid", cm_valid, 1);
      chk("R7 held value", cm_value, 4321);
      tick();
    end
    do_commit(0, 1, 4321);

    // R8 newest producer wins; release keeps newer mapping
    do_alloc(0, 2, 1);
    do_alloc(0, 2, 2);
    look0(2);
    chk("R5 newest tag", look_tag[1:0], 2);
    chk("R5 not ready", look_ready[0], 0);
    do_wb(1, 100, 0);
    look0(2);
    chk("R5 older done not ready", look_ready[0], 0);
    do_wb(2, 200, 0);
    look0(2);
    chk("R5 ready value", look_value[15:0], 200);
    do_commit(1, 2, 100);
    look0(2);
    chk("R8 still busy", look_busy[0], 1);
    chk("R8 still newer tag", look_tag[1:0], 2);
    do_commit(2, 2, 200);
    look0(2);
    chk("R8 freed", look_busy[0], 0);

    // R9 store and branch install no mapping
    do_alloc(1, 3, 3);
    do_alloc(2, 0, 0);
    look0(3);
    chk("R9 store no map", look_busy[0], 0);
    look0(0);
    chk("R9 branch no map", look_busy[0], 0);
    do_wb(3, 7, 0);
    do_wb(0, 0, 0);
    #1;
    chk("R9 store kind", cm_kind, 1);
    do_commit(3, 3, 7);
    #1;
    chk("R9 branch kind", cm_kind, 2);
    chk("R9 no mispredict", cm_mispredict, 0);
    do_commit(0, 0, 0);

    // R10 external flush
    do_alloc(0, 1, 1);
    do_alloc(0, 2, 2);
    do_alloc(0, 3, 3);
    do_wb(1, 9, 0);
    flush_in = 1; alloc_valid = 1; alloc_kind = 0; alloc_dest = 0;
    #1;
    chk("R10 alloc_ready low", alloc_ready, 0);
    chk("R10 cm_valid low", cm_valid, 0);
    tick();
    flush_in = 0; alloc_valid = 0;
    for (int k = 0; k < 4; k++) begin
      look0(k);
      chk("R10 map clear", look_busy[0], 0);
    end
    chk("R10 empty", cm_valid, 0);
    do_alloc(0, 1, 0);
    do_wb(0, 11, 0);
    do_commit(0, 1, 11);

    // R11 mispredicted branch at commit
    do_alloc(2, 0, 1);
    do_alloc(0, 3, 2);
    do_wb(1, 0, 1);
    #1;
    chk("R11 alloc_ready low", alloc_ready, 0);
    chk("R11 cm_mispredict", cm_mispredict, 1);
    do_commit(1, 0, 0);
    look0(3);
    chk("R11 map cleared", look_busy[0], 0);
    chk("R11 empty", cm_valid, 0);
    do_alloc(0, 1, 0);
    do_wb(0, 12, 0);
    do_commit(0, 1, 12);

    // R4 write to a free slot is dropped; R2 wrap
    do_wb(3, 55, 0);
    do_alloc(0, 0, 1);
    do_alloc(0, 1, 2);
    do_alloc(0, 2, 3);
    do_wb(1, 21, 0);
    do_wb(2, 22, 0);
    do_commit(1, 0, 21);
    do_commit(2, 1, 22);
    #1;
    chk("R4 stale write dropped", cm_valid, 0);
    look0(2);
    chk("R4 lookup not ready", look_ready[0], 0);
    do_wb(3, 23, 0);
    do_commit(3, 2, 23);
    do_alloc(0, 0, 0);
    do_wb(0, 1, 0);
    do_commit(0, 0, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule